// File: doc/BRIEF.md
# Stream Handshake Rule Monitor

This block sits passively beside one ready/valid stream link and watches its valid, ready, data, last and reset wires. It never drives the link and never applies back-pressure. It raises a sticky flag whenever the sender breaks a handshake rule. There are three rule classes. The first is valid being high when reset rules forbid it. The second is valid being withdrawn while a beat is stalled. The third is the payload (data or last) changing while a beat is stalled. Each flag stays set until the clear input is pulsed. The same clear also zeroes a counter of accepted beats.

The monitor samples everything on its own clock edge. The observed link reset may be treated as synchronous or asynchronous (parameter `ASYNC_RESET`). In synchronous mode a sender may still show valid during the reset cycle, but must show it low on the cycle after. In asynchronous mode valid must also be low on any cycle in which reset is high. On the very first clock after power-up the monitor assumes reset was active. It skips the reset check in that cycle unless `VALID_INIT_ZERO` promises that the sender powers up with valid low.

Top module: `streamRuleMon`

## Requirements
- R1: If `linkRst` was high on the previous sampled cycle and `tValid` is high now, `errReset` is set at the next clock edge.
- R2: With `ASYNC_RESET`=1, `tValid` high in a cycle where `linkRst` is high sets `errReset`. With `ASYNC_RESET`=0 that alone sets no flag.
- R3: On the first clock cycle after power-up, `tValid` high sets `errReset` only when `VALID_INIT_ZERO`=1.
- R4: If the previous cycle had `tValid`=1, `tReady`=0 and `linkRst`=0, and `tValid` is now 0, `errDrop` is set.
- R5: If the previous cycle had `tValid`=1, `tReady`=0 and `linkRst`=0, and `tValid` is still 1 but `tData` or `tLast` differs from its previous value, `errPayload` is set.
- R6: A link reset in a stalled cycle, or (in asynchronous mode) in the current cycle, exempts the current cycle from the R4 and R5 checks.
- R7: A legal sequence sets no flag, and each violation sets only its own flag.
- R8: Flags are sticky. A cycle with `clearAll`=1 zeroes them at the next edge, unless a violation is seen in that same cycle, in which case that violation's flag is set.
- R9: `beatCount` rises by one at each edge where `tValid` and `tReady` were both 1. It returns to 0 at the edge after `clearAll`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, same as link clock |
| linkRst | input | 1 | Observed link reset, active high |
| tValid | input | 1 | Observed valid |
| tReady | input | 1 | Observed ready |
| tData | input | DATA_W | Observed data |
| tLast | input | 1 | Observed end-of-packet marker |
| clearAll | input | 1 | Clears flags and beat counter |
| errReset | output | 1 | Sticky reset-rule violation |
| errDrop | output | 1 | Sticky valid-withdrawn-in-stall violation |
| errPayload | output | 1 | Sticky payload-changed-in-stall violation |
| beatCount | output | CNT_W | Accepted beat count |

## Verification
The hardest case to reach is a rule whose outcome depends on two successive cycles, such as reset and stall in one cycle followed by a valid drop in the next. Only a sequence of exactly those two cycles exposes a wrong exemption. The stimulus therefore sweeps every mix of reset, valid and ready in a first cycle against valid and payload change in a second. It runs the sweep on a synchronous and an asynchronous instance side by side, so one walk covers both reset modes. The power-up cycle is driven with valid already high at time zero, before any clear has occurred.

// File: rtl/streamRuleMonPkg.sv
package streamRuleMonPkg;
  typedef struct packed {
    logic rstViol;
    logic dropViol;
    logic holdChk;
    logic beat;
  } monStrobe_t;
endpackage

// File: rtl/streamRuleMonCtrl.sv
module streamRuleMonCtrl
  import streamRuleMonPkg::*;
#(
  parameter bit ASYNC_RESET     = 1'b0,
  parameter bit VALID_INIT_ZERO = 1'b0
) (
  input  logic       clk,
  input  logic       linkRst,
  input  logic       tValid,
  input  logic       tReady,
  output monStrobe_t strobe
);
  // history of the link, with power-up values chosen as "reset was on"
  logic pastValid = 1'b0;
  logic prevRst   = 1'b1;
  logic stallQ    = 1'b0;
  logic exemptNow;
  logic rstRule;

  generate
    if (ASYNC_RESET) begin : g_async
      assign exemptNow = linkRst;
    end else begin : g_sync
      assign exemptNow = 1'b0;
    end
  endgenerate

  always_comb begin
    rstRule = pastValid ? prevRst : VALID_INIT_ZERO;
    strobe.rstViol  = tValid && (rstRule || exemptNow);
    strobe.dropViol = stallQ && !tValid && !exemptNow;
    strobe.holdChk  = stallQ && tValid && !exemptNow;
    strobe.beat     = tValid && tReady;
  end

  always_ff @(posedge clk) begin
    pastValid <= 1'b1;
    prevRst   <= linkRst;
    stallQ    <= tValid && !tReady && !linkRst;
  end

  // R7: at most one class of rule is active in any cycle
  a_r7_one_rule: assert property (@(posedge clk) disable iff (!pastValid)
    $onehot0({strobe.rstViol, strobe.dropViol, strobe.holdChk}));

  // R6: a stall entered while reset was high never arms the hold checks
  a_r6_rst_no_stall: assert property (@(posedge clk) disable iff (!pastValid)
    linkRst |=> !(strobe.dropViol || strobe.holdChk));
endmodule

// File: rtl/streamRuleMonData.sv
module streamRuleMonData
  import streamRuleMonPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  monStrobe_t        strobe,
  input  logic [DATA_W-1:0] tData,
  input  logic              tLast,
  input  logic              clearAll,
  output logic              errReset,
  output logic              errDrop,
  output logic              errPayload,
  output logic [CNT_W-1:0]  beatCount
);
  localparam int PAY_W = DATA_W + 1;

  logic [PAY_W-1:0] payNow;
  logic [PAY_W-1:0] payPrev  = '0;
  logic             flagRst  = 1'b0;
  logic             flagDrop = 1'b0;
  logic             flagPay  = 1'b0;
  logic [CNT_W-1:0] cnt      = '0;
  logic             live     = 1'b0;
  logic             payMiss;

  assign payNow  = {tLast, tData};
  assign payMiss = strobe.holdChk && (payNow != payPrev);

  always_ff @(posedge clk) begin
    live     <= 1'b1;
    payPrev  <= payNow;
    flagRst  <= (flagRst  && !clearAll) || strobe.rstViol;
    flagDrop <= (flagDrop && !clearAll) || strobe.dropViol;
    flagPay  <= (flagPay  && !clearAll) || payMiss;
    if (clearAll)         cnt <= '0;
    else if (strobe.beat) cnt <= cnt + 1'b1;
  end

  assign errReset   = flagRst;
  assign errDrop    = flagDrop;
  assign errPayload = flagPay;
  assign beatCount  = cnt;

  // R8: flags stay set without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!live)
    (!clearAll && (flagRst || flagDrop || flagPay))
      |=> ({flagRst, flagDrop, flagPay} & $past({flagRst, flagDrop, flagPay}))
          == $past({flagRst, flagDrop, flagPay}));

  // R8: a clear with no violation empties all flags
  a_r8_clear: assert property (@(posedge clk) disable iff (!live)
    (clearAll && !strobe.rstViol && !strobe.dropViol && !payMiss)
      |=> !(flagRst || flagDrop || flagPay));

  // R9: accepted beat advances the counter by one
  a_r9_count_step: assert property (@(posedge clk) disable iff (!live)
    (strobe.beat && !clearAll) |=> cnt == $past(cnt) + 1'b1);

  // R9: no beat, no clear, counter holds
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!live)
    (!strobe.beat && !clearAll) |=> $stable(cnt));
endmodule

// File: rtl/streamRuleMon.sv
module streamRuleMon
  import streamRuleMonPkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int CNT_W           = 32,
  parameter bit ASYNC_RESET     = 1'b0,
  parameter bit VALID_INIT_ZERO = 1'b0
) (
  input  logic              clk,
  input  logic              linkRst,
  input  logic              tValid,
  input  logic              tReady,
  input  logic [DATA_W-1:0] tData,
  input  logic              tLast,
  input  logic              clearAll,
  output logic              errReset,
  output logic              errDrop,
  output logic              errPayload,
  output logic [CNT_W-1:0]  beatCount
);
  monStrobe_t strobe;

  streamRuleMonCtrl #(
    .ASYNC_RESET    (ASYNC_RESET),
    .VALID_INIT_ZERO(VALID_INIT_ZERO)
  ) ctrl (
    .clk    (clk),
    .linkRst(linkRst),
    .tValid (tValid),
    .tReady (tReady),
    .strobe (strobe)
  );

  streamRuleMonData #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) data (
    .clk       (clk),
    .strobe    (strobe),
    .tData     (tData),
    .tLast     (tLast),
    .clearAll  (clearAll),
    .errReset  (errReset),
    .errDrop   (errDrop),
    .errPayload(errPayload),
    .beatCount (beatCount)
  );
endmodule

// File: tb/streamRuleMon_test.sv
module streamRuleMon_test;
  localparam int DW = 8;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic linkRst = 1'b0, tValid = 1'b1, tReady = 1'b0, tLast = 1'b0, clearAll = 1'b0;
  logic [DW-1:0] tData = 8'h3C;
  logic sErrRst, sErrDrop, sErrPay, aErrRst, aErrDrop, aErrPay;
  logic [CW-1:0] sCnt, aCnt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  streamRuleMon #(.DATA_W(DW), .CNT_W(CW), .ASYNC_RESET(1'b0), .VALID_INIT_ZERO(1'b0)) uut (
    .clk(clk), .linkRst(linkRst), .tValid(tValid), .tReady(tReady), .tData(tData),
    .tLast(tLast), .clearAll(clearAll), .errReset(sErrRst), .errDrop(sErrDrop),
    .errPayload(sErrPay), .beatCount(sCnt));

  streamRuleMon #(.DATA_W(DW), .CNT_W(CW), .ASYNC_RESET(1'b1), .VALID_INIT_ZERO(1'b1)) uutAsync (
    .clk(clk), .linkRst(linkRst), .tValid(tValid), .tReady(tReady), .tData(tData),
    .tLast(tLast), .clearAll(clearAll), .errReset(aErrRst), .errDrop(aErrDrop),
    .errPayload(aErrPay), .beatCount(aCnt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleClear();
    linkRst = 1'b0; tValid = 1'b0; tReady = 1'b0; clearAll = 1'b1;
    step();
    clearAll = 1'b0;
  endtask

  initial begin
    // R3: valid already high at power-up, before any edge
    step();
    chk("R3 sync first cycle exempt", sErrRst, 0);
    chk("R3 async init-zero first cycle", aErrRst, 1);
    tReady = 1'b1;
    step();
    idleClear();
    chk("R8 clear after power-up", {sErrRst, sErrDrop, sErrPay, aErrRst, aErrDrop, aErrPay}, 0);
    chk("R9 count cleared", sCnt, 0);

    // two-cycle sweep: reset, valid, ready in cycle A; valid, payload change in cycle B
    for (int k = 0; k < 32; k++) begin
      logic r1, v1, q1, v2, ch;
      logic [DW-1:0] d;
      {r1, v1, q1, v2, ch} = k[4:0];
      d = 8'(k * 37 + 5);
      idleClear();
      linkRst = r1; tValid = v1; tReady = q1; tData = d; tLast = d[1];
      step();
      linkRst = 1'b0; tValid = v2; tReady = 1'b1;
      tData = ch ? (k[0] ? d ^ 8'h5A : d) : d;
      tLast = ch ? (k[0] ? d[1] : ~d[1]) : d[1];
      step();
      chk("R1 sync reset flag", sErrRst, r1 & v2);
      chk("R2 async reset flag", aErrRst, r1 & (v1 | v2));
      chk("R4 R6 sync drop flag", sErrDrop, !r1 & v1 & !q1 & !v2);
      chk("R4 R6 async drop flag", aErrDrop, !r1 & v1 & !q1 & !v2);
      chk("R5 R7 sync payload flag", sErrPay, !r1 & v1 & !q1 & v2 & ch);
      chk("R5 R7 async payload flag", aErrPay, !r1 & v1 & !q1 & v2 & ch);
      chk("R9 sync beat count", sCnt, 32'(v1 & q1) + 32'(v2));
      chk("R9 async beat count", aCnt, 32'(v1 & q1) + 32'(v2));
    end

    // R6: async reset during stall cycle B exempts the drop
    idleClear();
    tValid = 1'b1; tReady = 1'b0; tData = 8'h11;
    step();
    tValid = 1'b0; linkRst = 1'b1;
    step();
    chk("R6 async current reset exempts drop", aErrDrop, 0);
    chk("R6 sync current reset still drop", sErrDrop, 1);
    linkRst = 1'b0;

    // R8: stickiness, clear, and clear colliding with a violation
    idleClear();
    tValid = 1'b1; tReady = 1'b0; tData = 8'h22;
    step();
    tValid = 1'b0;
    step();
    for (int i = 0; i < 3; i++) step();
    chk("R8 drop flag sticky", sErrDrop, 1);
    chk("R7 only drop flag", {sErrRst, sErrPay}, 0);
    clearAll = 1'b1;
    step();
    clearAll = 1'b0;
    chk("R8 clear zeroes flag", sErrDrop, 0);
    tValid = 1'b1; tReady = 1'b0;
    step();
    tValid = 1'b0; clearAll = 1'b1;
    step();
    clearAll = 1'b0;
    chk("R8 violation beats clear", sErrDrop, 1);

    // R9: long run of accepted beats with gaps
    idleClear();
    for (int i = 0; i < 20; i++) begin
      tValid = (i % 3) != 0; tReady = 1'b1; tData = 8'(i);
      step();
    end
    tValid = 1'b0;
    step();
    chk("R9 count of gapped beats", sCnt, 13);
    chk("R7 legal run no flags", {sErrRst, sErrDrop, sErrPay}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule